// File: doc/BRIEF.md
# Byte-wide SPI master/slave controller

This block moves one byte at a time over a four-wire serial link. A configuration bit selects its role. As a master it derives the serial clock from the system clock, drives the clock and the outgoing data line, and samples the returning line. As a slave it follows an external serial clock while the external select line is held low. The configuration fields are bit order, role, clock idle level, clock phase, a two-bit rate select and a double-speed bit. All of them are loaded together by one write strobe. Software loads the byte to send with a data write strobe. It learns that a transfer has finished from a completion flag, and it reads the received byte from a parallel output.

In master mode the select line acts as a fault input. If another device pulls it low, the block gives up the master role, releases its clock and data drivers, and raises the completion flag. It stays a slave until software writes the configuration again. In slave mode the clock, select and data inputs pass through a two-stage synchronizer. The external clock must therefore be slow compared with the system clock. Each of its half periods has to last several system clocks.

Top module: `spi_port_ctrl`

## Requirements
- R1: With `cfg_lsb_first`=1, bit 0 of the byte is the first bit on the line and the first bit received lands in bit 0. With `cfg_lsb_first`=0, bit 7 goes first and the first bit received lands in bit 7.
- R2: A master idles its clock at the level of `cfg_cpol`. `sck_oe` and `mosi_oe` are high only in master mode, and a write of `cfg_master`=1 selects master mode, which `master_o` reports.
- R3: With `cfg_cpha`=0, data is sampled on the leading clock edge (the edge away from the idle level) and changed on the trailing edge, and the first bit is present before the first edge. With `cfg_cpha`=1, data is changed on the leading edge and sampled on the trailing edge.
- R4: A master's clock period, in system clocks, is 4, 16, 64 or 128 for `cfg_rate` = 0, 1, 2 or 3 with `cfg_dbl`=0. With `cfg_dbl`=1 it is 2, 8, 32 or 64. Each half period is half of that.
- R5: A transfer is exactly 8 clock periods (16 edges). `done` rises after the eighth sampled bit, and `rx_data` then holds the received byte.
- R6: `done` clears only on an `rx_rd` strobe that follows an `stat_rd` strobe issued while `done` was high. An `rx_rd` without that earlier `stat_rd` leaves it set.
- R7: In master mode a low `ss_n_i` clears the master role, sets `done`, and drops `sck_oe` and `mosi_oe`. The block stays a slave after `ss_n_i` returns high, until a configuration write sets the master role again.
- R8: In slave mode `miso_oe` is high only while `ss_n_i` is low. A high `ss_n_i` resets the bit position, so a partial transfer that select aborts has no effect on the next one.
- R9: `cfg_rate` and `cfg_dbl` have no effect in slave mode. A slave transfer completes correctly for any rate setting at the pace of the external clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads all configuration fields |
| cfg_lsb_first | input | 1 | Bit order: 1 = least significant bit first |
| cfg_master | input | 1 | Role: 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge |
| cfg_rate | input | 2 | Master clock rate select |
| cfg_dbl | input | 1 | Double-speed: halves the master divider |
| master_o | output | 1 | Current role: 1 = master |
| tx_wr | input | 1 | Loads `tx_data`; starts a transfer in idle master mode |
| tx_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| rx_rd | input | 1 | Received-byte read strobe |
| rx_data | output | 8 | Last byte received |
| done | output | 1 | Completion / mode-fault flag |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line input (slave) |
| mosi_o | output | 1 | Master-out line output |
| mosi_oe | output | 1 | Master-out line output enable |
| miso_i | input | 1 | Master-in line input (master) |
| miso_o | output | 1 | Master-in line output (slave) |
| miso_oe | output | 1 | Master-in line output enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The assertions check several properties on every cycle. An idle master's clock sits at the polarity level. The divider count stays inside the selected half period. A synchronized high select keeps the slave data line released. A select-low fault demotes the block and raises the flag in the next cycle. The flag never drops without a read strobe. Only the bench's scenarios can show that bit order and phase are right, since that needs whole bytes observed edge by edge at the pins. The same holds for the exact half-period length of each rate, the two-step flag clearing, and the recovery after an aborted slave transfer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned HALF_W = 7;

    typedef struct packed {
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic       dbl;
        logic [1:0] rate;
    } spi_cfg_t;

    typedef struct packed {
        logic valid;
        logic leading;
    } sck_edge_t;

    // System clocks per serial-clock half period.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
        logic [2:0] sh;
        case (rate)
            2'd0:    sh = 3'd1;
            2'd1:    sh = 3'd3;
            2'd2:    sh = 3'd5;
            default: sh = 3'd6;
        endcase
        if (dbl) sh = sh - 3'd1;
        return HALF_W'(1) << sh;
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_port_pkg::*;
#(
    parameter int unsigned BITS = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [HALF_W-1:0] half,
    output sck_edge_t         ev,
    output logic              level,
    output logic              active,
    output logic [HALF_W-1:0] div_cnt
);
    localparam int unsigned EW = $clog2(2 * BITS);

    logic [EW-1:0] edge_cnt_q;
    logic          tick;

    always_comb begin
        tick       = active && (div_cnt == half - HALF_W'(1));
        ev.valid   = tick;
        ev.leading = !edge_cnt_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active     <= 1'b0;
            level      <= 1'b0;
            div_cnt    <= '0;
            edge_cnt_q <= '0;
        end else if (start) begin
            active     <= 1'b1;
            level      <= 1'b0;
            div_cnt    <= '0;
            edge_cnt_q <= '0;
        end else if (tick) begin
            div_cnt    <= '0;
            level      <= ~level;
            edge_cnt_q <= edge_cnt_q + EW'(1);
            if (edge_cnt_q == EW'(2 * BITS - 1)) active <= 1'b0;
        end else if (active) begin
            div_cnt <= div_cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_port_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_i,
    input  logic      ss_n_i,
    input  logic      mosi_i,
    input  logic      cpol,
    input  logic      enable,
    output logic      ss_low,
    output logic      mosi_s,
    output sck_edge_t ev
);
    logic [STAGES-1:0] sck_p, ss_p, mosi_p;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            ss_p     <= '1;
            mosi_p   <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_i};
            ss_p     <= {ss_p[STAGES-2:0], ss_n_i};
            mosi_p   <= {mosi_p[STAGES-2:0], mosi_i};
            sck_last <= sck_p[STAGES-1];
        end
    end

    always_comb begin
        ss_low     = !ss_p[STAGES-1];
        mosi_s     = mosi_p[STAGES-1];
        ev.valid   = enable && ss_low && (sck_p[STAGES-1] != sck_last);
        ev.leading = sck_p[STAGES-1] ^ cpol;
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_port_pkg::*;
#(
    parameter int unsigned BITS = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            restart,
    input  sck_edge_t       ev,
    input  logic            lsb_first,
    input  logic            cpha,
    input  logic            in_bit,
    output logic            out_bit,
    output logic            done_p,
    output logic [BITS-1:0] rx_byte
);
    localparam int unsigned IW = $clog2(BITS);

    logic [BITS-1:0] tx_q, rx_q, rx_next;
    logic [IW-1:0]   out_idx_q, bit_cnt_q;
    logic            first_q, is_sample;

    always_comb begin
        is_sample = ev.leading ^ cpha;
        rx_next   = lsb_first ? {in_bit, rx_q[BITS-1:1]} : {rx_q[BITS-2:0], in_bit};
        out_bit   = lsb_first ? tx_q[out_idx_q] : tx_q[IW'(BITS - 1) - out_idx_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            rx_q      <= '0;
            rx_byte   <= '0;
            out_idx_q <= '0;
            bit_cnt_q <= '0;
            first_q   <= 1'b1;
            done_p    <= 1'b0;
        end else begin
            done_p <= 1'b0;
            if (load) tx_q <= load_data;
            if (restart) begin
                out_idx_q <= '0;
                bit_cnt_q <= '0;
                first_q   <= 1'b1;
            end else if (ev.valid) begin
                if (is_sample) begin
                    rx_q <= rx_next;
                    if (bit_cnt_q == IW'(BITS - 1)) begin
                        bit_cnt_q <= '0;
                        done_p    <= 1'b1;
                        rx_byte   <= rx_next;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + IW'(1);
                    end
                end else if (cpha && first_q) begin
                    first_q <= 1'b0;
                end else if (out_idx_q == IW'(BITS - 1)) begin
                    out_idx_q <= '0;
                end else begin
                    out_idx_q <= out_idx_q + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_lsb_first,
    input  logic       cfg_master,
    input  logic       cfg_cpol,
    input  logic       cfg_cpha,
    input  logic [1:0] cfg_rate,
    input  logic       cfg_dbl,
    output logic       master_o,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       stat_rd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       done,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);
    spi_cfg_t          cfg_q;
    logic              armed_q;
    logic              fault, start, restart, load, in_bit, out_bit, done_p;
    logic              ss_low, mosi_s, gen_level, gen_active;
    logic [HALF_W-1:0] half, div_cnt;
    sck_edge_t         gen_ev, slv_ev, ev;

    assign half = half_period(cfg_q.rate, cfg_q.dbl);

    spi_slave_front #(.STAGES(2)) i_front (
        .clk(clk), .rst(rst), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .cpol(cfg_q.cpol), .enable(!cfg_q.master),
        .ss_low(ss_low), .mosi_s(mosi_s), .ev(slv_ev)
    );

    spi_sck_gen #(.BITS(DATA_W)) i_gen (
        .clk(clk), .rst(rst), .start(start), .abort(fault), .half(half),
        .ev(gen_ev), .level(gen_level), .active(gen_active), .div_cnt(div_cnt)
    );

    always_comb begin
        fault   = cfg_q.master && ss_low;
        start   = tx_wr && cfg_q.master && !gen_active && !fault;
        restart = start || (!cfg_q.master && !ss_low);
        load    = tx_wr && !(cfg_q.master && gen_active);
        ev      = cfg_q.master ? gen_ev : slv_ev;
        in_bit  = cfg_q.master ? miso_i : mosi_s;
    end

    spi_shifter #(.BITS(DATA_W)) i_shift (
        .clk(clk), .rst(rst), .load(load), .load_data(tx_data), .restart(restart),
        .ev(ev), .lsb_first(cfg_q.lsb_first), .cpha(cfg_q.cpha), .in_bit(in_bit),
        .out_bit(out_bit), .done_p(done_p), .rx_byte(rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            done    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg_q <= '{lsb_first: cfg_lsb_first, master: cfg_master, cpol: cfg_cpol,
                           cpha: cfg_cpha, dbl: cfg_dbl, rate: cfg_rate};
            end else if (fault) begin
                cfg_q.master <= 1'b0;
            end
            if (done_p || fault) begin
                done    <= 1'b1;
                armed_q <= 1'b0;
            end else if (rx_rd && armed_q) begin
                done    <= 1'b0;
                armed_q <= 1'b0;
            end else if (stat_rd && done) begin
                armed_q <= 1'b1;
            end
        end
    end

    always_comb begin
        master_o = cfg_q.master;
        sck_o    = cfg_q.cpol ^ gen_level;
        sck_oe   = cfg_q.master;
        mosi_o   = out_bit;
        mosi_oe  = cfg_q.master;
        miso_o   = out_bit;
        miso_oe  = !cfg_q.master && ss_low;
    end
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk
    import spi_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              rx_rd,
    input logic              master_q,
    input logic              cpol_q,
    input logic              gen_active,
    input logic [HALF_W-1:0] div_cnt,
    input logic [HALF_W-1:0] half,
    input logic              ss_low,
    input logic              done_p,
    input logic              done,
    input logic              sck_o,
    input logic              miso_oe
);
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (master_q && !gen_active) |-> (sck_o == cpol_q));

    p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
        gen_active |-> (div_cnt < half));

    p_done_sets_r5: assert property (@(posedge clk) disable iff (rst)
        done_p |=> done);

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !rx_rd) |=> done);

    p_fault_demote_r7: assert property (@(posedge clk) disable iff (rst)
        (master_q && ss_low && !cfg_wr) |=> (!master_q && done));

    p_miso_release_r8: assert property (@(posedge clk) disable iff (rst)
        !ss_low |-> !miso_oe);
endmodule

bind spi_port_ctrl spi_port_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .rx_rd(rx_rd),
    .master_q(cfg_q.master), .cpol_q(cfg_q.cpol), .gen_active(gen_active),
    .div_cnt(div_cnt), .half(half), .ss_low(ss_low), .done_p(done_p),
    .done(done), .sck_o(sck_o), .miso_oe(miso_oe)
);

// File: tb/test_spi_port_ctrl.sv
module test_spi_port_ctrl;
    logic       clk = 1'b0, rst = 1'b1;
    logic       cfg_wr = 0, cfg_lsb_first = 0, cfg_master = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_dbl = 0;
    logic [1:0] cfg_rate = 0;
    logic       tx_wr = 0, stat_rd = 0, rx_rd = 0;
    logic [7:0] tx_data = 0;
    logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
    logic       master_o, done, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic [7:0] rx_data;
    int         checks = 0, errors = 0, cycles = 0;
    bit         finished = 0;

    spi_port_ctrl i_spi_port_ctrl (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [1:0] rate, input logic dbl);
        int per;
        case (rate)
            2'd0: per = 4;
            2'd1: per = 16;
            2'd2: per = 64;
            default: per = 128;
        endcase
        if (dbl) per = per / 2;
        return per / 2;
    endfunction

    function automatic logic bit_at(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    task automatic cfg_set(input logic lsb, input logic mst, input logic cpol, input logic cpha,
                           input logic [1:0] rate, input logic dbl);
        @(negedge clk);
        cfg_lsb_first = lsb; cfg_master = mst; cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_rate = rate; cfg_dbl = dbl; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0; rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask

    task automatic master_xfer(input logic lsb, input logic cpol, input logic cpha,
                               input logic [1:0] rate, input logic dbl,
                               input logic [7:0] txb, input logic [7:0] devb);
        int hp = exp_half(rate, dbl);
        int cyc = 0, last = 0, edges = 0, si = 0;
        bit bad_iv = 0, extra = 0;
        logic prev;
        logic [7:0] seq = 0, exp_seq;
        cfg_set(lsb, 1'b1, cpol, cpha, rate, dbl);
        clear_flag();
        check(sck_o == cpol && sck_oe && mosi_oe && master_o, "R2 master idle", {sck_o, sck_oe, mosi_oe, master_o}, {cpol, 3'b111});
        miso_i = cpha ? 1'b0 : bit_at(devb, 0, lsb);
        tx_data = txb; tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
        prev = sck_o;
        while (edges < 16 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (sck_o != prev) begin
                logic lead = (sck_o ^ cpol);
                if (cyc - last != hp) bad_iv = 1;
                last = cyc;
                if (lead ^ cpha) begin
                    seq[si] = mosi_o; si++;
                end else if (si < 8) begin
                    miso_i = bit_at(devb, si, lsb);
                end
                prev = sck_o;
                edges++;
            end
        end
        repeat (4) begin
            @(negedge clk);
            if (sck_o != prev) extra = 1;
        end
        for (int i = 0; i < 8; i++) exp_seq[i] = bit_at(txb, i, lsb);
        check(!bad_iv, "R4 half period", hp, hp);
        check(edges == 16 && !extra && sck_o == cpol, "R5 sixteen edges then idle", edges, 16);
        check(seq == exp_seq, "R1/R3 master line order", seq, exp_seq);
        check(done == 1'b1, "R5 master done", done, 1);
        check(rx_data == devb, "R5 master rx", rx_data, devb);
    endtask

    task automatic slave_xfer(input logic lsb, input logic cpol, input logic cpha,
                              input logic [1:0] rate, input logic dbl,
                              input logic [7:0] devtx, input logic [7:0] mosib, input int pre);
        int hp = 6, si = 0;
        logic [7:0] seq = 0, exp_seq;
        cfg_set(lsb, 1'b0, cpol, cpha, rate, dbl);
        clear_flag();
        sck_i = cpol;
        @(negedge clk); tx_data = devtx; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
        check(!miso_oe && !sck_oe && !mosi_oe, "R8 slave released while deselected", miso_oe, 0);
        if (pre > 0) begin
            ss_n_i = 0;
            repeat (hp) @(negedge clk);
            for (int e = 0; e < pre; e++) begin
                sck_i = ~sck_i; mosi_i = ~mosi_i;
                repeat (hp) @(negedge clk);
            end
            ss_n_i = 1;
            repeat (hp) @(negedge clk);
            check(done == 1'b0, "R8 aborted partial sets no flag", done, 0);
        end
        ss_n_i = 0;
        mosi_i = cpha ? 1'b0 : bit_at(mosib, 0, lsb);
        repeat (hp) @(negedge clk);
        check(miso_oe == 1'b1, "R8 slave drives when selected", miso_oe, 1);
        for (int e = 0; e < 16; e++) begin
            logic lead = (e % 2 == 0);
            if (lead ^ cpha) begin
                seq[si] = miso_o; si++;
                sck_i = ~sck_i;
            end else begin
                sck_i = ~sck_i;
                if (si < 8) mosi_i = bit_at(mosib, si, lsb);
            end
            repeat (hp) @(negedge clk);
        end
        for (int i = 0; i < 8; i++) exp_seq[i] = bit_at(devtx, i, lsb);
        check(seq == exp_seq, "R1/R3 slave line order", seq, exp_seq);
        check(done == 1'b1 && rx_data == mosib, "R5/R9 slave rx", rx_data, mosib);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        check(miso_oe == 1'b0, "R8 released after deselect", miso_oe, 0);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5eed);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!master_o && !done && !sck_oe && !mosi_oe && !miso_oe && rx_data == 8'h00,
              "R2 reset state", {master_o, done, sck_oe, mosi_oe, miso_oe}, 0);

        // R4: every rate in both speeds
        for (int r = 0; r < 4; r++)
            for (int d = 0; d < 2; d++)
                master_xfer(1'(r), 1'(d), 1'(r >> 1), 2'(r), 1'(d), 8'h3c ^ 8'(r * 17), 8'ha5 ^ 8'(d * 66));

        // R6: two-step flag clearing
        check(done == 1'b1, "R6 flag set before reads", done, 1);
        @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
        @(negedge clk);
        check(done == 1'b1, "R6 rx read alone keeps flag", done, 1);
        clear_flag();
        @(negedge clk);
        check(done == 1'b0, "R6 status then rx read clears", done, 0);

        // R7: mode fault
        cfg_set(0, 1, 1, 0, 2'd1, 0);
        @(negedge clk); ss_n_i = 0;
        repeat (4) @(negedge clk);
        check(!master_o && done && !sck_oe && !mosi_oe, "R7 fault demotes", {master_o, done, sck_oe}, 3'b010);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        check(!master_o, "R7 stays slave", master_o, 0);
        cfg_set(0, 1, 1, 0, 2'd1, 0);
        check(master_o && sck_oe, "R7 master restored by write", master_o, 1);

        // R8: aborted partial slave transfer, then a clean one
        slave_xfer(0, 0, 0, 2'd0, 0, 8'h96, 8'h5a, 2);
        slave_xfer(1, 1, 1, 2'd3, 1, 8'h81, 8'h7e, 0);

        // Random mix
        for (int k = 0; k < 8; k++) begin
            logic [3:0] m = 4'($urandom);
            master_xfer(m[0], m[1], m[2], 2'($urandom_range(0, 2)), m[3], 8'($urandom), 8'($urandom));
        end
        for (int k = 0; k < 6; k++) begin
            logic [5:0] m = 6'($urandom);
            slave_xfer(m[0], m[1], m[2], m[4:3], m[5], 8'($urandom), 8'($urandom), 0); // R9 any rate
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule